// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block collects level-sensitive interrupt requests from a set of devices and merges them onto four shared interrupt lines. Every device has four interrupt pins. A fixed routing stage maps each pin to one shared line. The mapping rotates the pin number by the device's slot number. Devices behind a bridge are rotated twice: once by their own slot on the secondary bus, and once by the bridge's slot on the root bus.

The block does not OR the pins together directly. It keeps the last sampled level of every pin and turns each change into a +1 or -1 step. Each shared line has a counter that accumulates these steps. A line is driven high while its counter is nonzero. Any number of pins may change in the same clock cycle, and every change is counted in that cycle. A per-line count output is provided for debug. It can be tied to zero through a parameter.

Top module: `irq_share_agg`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, every line is low and every count reads zero. This holds whatever the pin inputs are during reset.
- R2: Pin p (0..3) of root device i (source index 4*i+p) is routed to line (p + ROOT_SLOT0 + i) mod 4.
- R3: Pin p of secondary device j (source index 4*(NUM_ROOT+j)+p) is first routed to bridge pin (p + j) mod 4. That bridge pin then goes to line ((p + j) mod 4 + BRIDGE_SLOT) mod 4.
- R4: The count of line l equals the number of asserted pins routed to l. Line l is high exactly when that count is nonzero, so dropping one of two sharing pins keeps the line high.
- R5: A pin held at its stored level has no effect: the counts stay constant for as long as the inputs do not change.
- R6: When several pins rise and fall in the same cycle, all of their steps are applied together in that cycle.
- R7: Lines and counts change one clock edge after the pin inputs that cause the change are sampled. They do not change combinationally.
- R8: The counters hold the full number of sources routed to each line with all pins asserted, and they never step below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pin_lvl_i | input | 4*(NUM_ROOT+NUM_SEC) | Pin levels; bit 4*d+p is pin p of device d, root devices first |
| line_o | output | 4 | Shared interrupt line levels |
| line_cnt_o | output | 4*CNT_W | Per-line asserted-source count, line l at bits [l*CNT_W +: CNT_W] (zero when DBG_EN is 0) |

## Verification
The bench uses three root devices starting at slot 1, two secondary devices and a bridge at slot 5. This gives 20 sources, with five on each line and a 5-bit counter. With these values every line is reached from both root and secondary devices, so both rotation stages are exercised. Each line can be filled to its full source count, and the secondary rotation wraps past line 3. The debug count is enabled, so the exact counter values are observable at the ports.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int PINS_PER_DEV = 4;
    localparam int NUM_LINES    = 4;
    localparam int LINE_W       = 2;

    typedef logic [LINE_W-1:0] line_t;

    // rotate a pin number by a slot number onto one of the four lines
    function automatic line_t swizzle(input int pin, input int slot);
        int sum;
        sum = pin + slot;
        return line_t'(sum % NUM_LINES);
    endfunction
endpackage

// File: rtl/irq_route.sv
module irq_route
    import irq_agg_pkg::*;
#(
    parameter int NUM_ROOT    = 3,
    parameter int NUM_SEC     = 2,
    parameter int ROOT_SLOT0  = 1,
    parameter int BRIDGE_SLOT = 5,
    localparam int NUM_DEV    = NUM_ROOT + NUM_SEC,
    localparam int NUM_SRC    = NUM_DEV * PINS_PER_DEV
) (
    output logic [NUM_SRC*LINE_W-1:0] route_o
);
    genvar gd, gp;
    generate
        for (gd = 0; gd < NUM_DEV; gd++) begin : g_dev
            for (gp = 0; gp < PINS_PER_DEV; gp++) begin : g_pin
                if (gd < NUM_ROOT) begin : g_root
                    // root bus: one rotation by the device's own slot
                    assign route_o[(gd*PINS_PER_DEV+gp)*LINE_W +: LINE_W] =
                        swizzle(gp, ROOT_SLOT0 + gd);
                end else begin : g_sec
                    // secondary bus: rotate onto a bridge pin, then by bridge slot
                    line_t bridge_pin;
                    assign bridge_pin = swizzle(gp, gd - NUM_ROOT);
                    assign route_o[(gd*PINS_PER_DEV+gp)*LINE_W +: LINE_W] =
                        swizzle(int'(bridge_pin), BRIDGE_SLOT);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_edge_tracker.sv
module irq_edge_tracker #(
    parameter int NUM_SRC = 20
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    output logic [NUM_SRC-1:0] rise_o,
    output logic [NUM_SRC-1:0] fall_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
    } trk_state_t;

    trk_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.lvl = lvl_i;
        rise_o      = lvl_i & ~state_q.lvl;
        fall_o      = ~lvl_i & state_q.lvl;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int CNT_W   = 5,
    parameter int LINE_ID = 0
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_SRC-1:0]        rise_i,
    input  logic [NUM_SRC-1:0]        fall_i,
    input  logic [NUM_SRC*LINE_W-1:0] route_i,
    output logic [CNT_W-1:0]          cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic [CNT_W-1:0] inc, dec;

    always_comb begin
        inc = '0;
        dec = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (route_i[k*LINE_W +: LINE_W] == line_t'(LINE_ID)) begin
                if (rise_i[k]) inc = inc + CNT_W'(1);
                if (fall_i[k]) dec = dec + CNT_W'(1);
            end
        end
        state_d     = state_q;
        state_d.cnt = state_q.cnt + inc - dec;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_ROOT    = 3,
    parameter int NUM_SEC     = 2,
    parameter int ROOT_SLOT0  = 1,
    parameter int BRIDGE_SLOT = 5,
    parameter bit DBG_EN      = 1'b1,
    localparam int NUM_DEV    = NUM_ROOT + NUM_SEC,
    localparam int NUM_SRC    = NUM_DEV * PINS_PER_DEV,
    localparam int CNT_W      = $clog2(NUM_SRC + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [NUM_SRC-1:0]         pin_lvl_i,
    output logic [NUM_LINES-1:0]       line_o,
    output logic [NUM_LINES*CNT_W-1:0] line_cnt_o
);
    logic [NUM_SRC*LINE_W-1:0]  route;
    logic [NUM_SRC-1:0]         rise, fall;
    logic [NUM_LINES*CNT_W-1:0] cnt_all;

    irq_route #(
        .NUM_ROOT    (NUM_ROOT),
        .NUM_SEC     (NUM_SEC),
        .ROOT_SLOT0  (ROOT_SLOT0),
        .BRIDGE_SLOT (BRIDGE_SLOT)
    ) u_route (
        .route_o (route)
    );

    irq_edge_tracker #(
        .NUM_SRC (NUM_SRC)
    ) u_track (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (pin_lvl_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
            irq_line_counter #(
                .NUM_SRC (NUM_SRC),
                .CNT_W   (CNT_W),
                .LINE_ID (gl)
            ) u_cnt (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .rise_i  (rise),
                .fall_i  (fall),
                .route_i (route),
                .cnt_o   (cnt_all[gl*CNT_W +: CNT_W])
            );
            assign line_o[gl] = |cnt_all[gl*CNT_W +: CNT_W];
        end
        if (DBG_EN) begin : g_dbg
            assign line_cnt_o = cnt_all;
        end else begin : g_nodbg
            assign line_cnt_o = '0;
        end
    endgenerate
endmodule

// File: rtl/irq_share_agg_chk.sv
module irq_share_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_ROOT    = 3,
    parameter int NUM_SEC     = 2,
    parameter int ROOT_SLOT0  = 1,
    parameter int BRIDGE_SLOT = 5,
    localparam int NUM_DEV    = NUM_ROOT + NUM_SEC,
    localparam int NUM_SRC    = NUM_DEV * PINS_PER_DEV,
    localparam int CNT_W      = $clog2(NUM_SRC + 1)
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic [NUM_SRC-1:0]         pin_lvl_i,
    input logic [NUM_LINES-1:0]       line_o,
    input logic [NUM_LINES*CNT_W-1:0] cnt_i
);
    // independent line mask: every source whose total rotation lands on l
    function automatic logic [NUM_SRC-1:0] mask_for(input int l);
        logic [NUM_SRC-1:0] m;
        int dev, pin, rot;
        m = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            dev = k / 4;
            pin = k % 4;
            rot = (dev < NUM_ROOT) ? (ROOT_SLOT0 + dev) : (dev - NUM_ROOT + BRIDGE_SLOT);
            if (((pin + rot) % 4) == l) m[k] = 1'b1;
        end
        return m;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        $past(rst_i) |-> (line_o == '0 && cnt_i == '0)); // R1

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LINES; gl++) begin : g_chk
            localparam logic [NUM_SRC-1:0] MASK = mask_for(gl);
            logic [CNT_W-1:0] cnt;
            assign cnt = cnt_i[gl*CNT_W +: CNT_W];

            AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
                !$past(rst_i) |-> (int'(cnt) == $countones($past(pin_lvl_i) & MASK))); // R4
            AST_LINE_OR: assert property (@(posedge clk_i) disable iff (rst_i)
                !$past(rst_i) |-> (line_o[gl] == |($past(pin_lvl_i) & MASK))); // R4
            AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
                int'(cnt) <= $countones(MASK)); // R8
            AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
                (cnt == '0 && !$past(rst_i)) |=> (int'(cnt) <= NUM_SRC)); // R8
        end
    endgenerate

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $stable(pin_lvl_i)) |=> $stable(cnt_i)); // R5
endmodule

bind irq_share_agg irq_share_agg_chk #(
    .NUM_ROOT    (NUM_ROOT),
    .NUM_SEC     (NUM_SEC),
    .ROOT_SLOT0  (ROOT_SLOT0),
    .BRIDGE_SLOT (BRIDGE_SLOT)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pin_lvl_i (pin_lvl_i),
    .line_o    (line_o),
    .cnt_i     (cnt_all)
);

// File: tb/irq_share_agg_bench.sv
`timescale 1ns/1ps
module irq_share_agg_bench;
    localparam int NR = 3, NS = 2, RS0 = 1, BS = 5;
    localparam int NSRC = (NR + NS) * 4;
    localparam int CW = $clog2(NSRC + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] pins = '0;
    logic [3:0]      lines;
    logic [4*CW-1:0] cnts;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_share_agg #(.NUM_ROOT(NR), .NUM_SEC(NS), .ROOT_SLOT0(RS0),
                    .BRIDGE_SLOT(BS), .DBG_EN(1'b1)) u_irq_share_agg (
        .clk_i(clk), .rst_i(rst), .pin_lvl_i(pins),
        .line_o(lines), .line_cnt_o(cnts));

    function automatic int exp_line(input int k);
        int d, p;
        d = k / 4; p = k % 4;
        if (d < NR) return (p + RS0 + d) % 4;
        return (((p + d - NR) % 4) + BS) % 4;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compare every line and count with the model of the current inputs
    task automatic chk_model(input string req);
        for (int l = 0; l < 4; l++) begin
            int e = 0;
            for (int k = 0; k < NSRC; k++)
                if (pins[k] && exp_line(k) == l) e++;
            chk(req, int'(cnts[l*CW +: CW]), e);
            chk(req, int'(lines[l]), int'(e != 0));
        end
    endtask

    task automatic apply(input logic [NSRC-1:0] v);
        @(negedge clk);
        pins = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        pins = '1;
        repeat (3) @(negedge clk);
        chk("R1", int'(lines), 0);
        chk("R1", int'(cnts), 0);
        pins = '0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(lines), 0);
        chk("R1", int'(cnts), 0);
    endtask

    task automatic t_single(input string req, input int lo, input int hi);
        for (int k = lo; k < hi; k++) begin
            apply(NSRC'(1) << k);
            chk(req, int'(lines), 1 << exp_line(k));
            chk(req, int'(cnts[exp_line(k)*CW +: CW]), 1);
        end
        apply('0);
        chk(req, int'(lines), 0);
    endtask

    task automatic t_or();
        int a, b;
        a = 0; b = -1;
        for (int k = 1; k < NSRC; k++)
            if (b < 0 && exp_line(k) == exp_line(a)) b = k;
        apply((NSRC'(1) << a) | (NSRC'(1) << b));
        chk("R4", int'(cnts[exp_line(a)*CW +: CW]), 2);
        apply(NSRC'(1) << b);
        chk("R4", int'(lines[exp_line(a)]), 1);
        chk("R4", int'(cnts[exp_line(a)*CW +: CW]), 1);
        apply('0);
        chk("R4", int'(lines[exp_line(a)]), 0);
        chk_model("R4");
    endtask

    task automatic t_hold();
        apply(NSRC'(20'h0_3005));
        chk_model("R5");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk_model("R5");
        end
        apply('0);
    endtask

    task automatic t_simul();
        apply(NSRC'(20'h5_A5A5));
        chk_model("R6");
        apply(NSRC'(20'hA_5A5A));   // every pin toggles in one cycle
        chk_model("R6");
        apply(NSRC'(20'hF_0F0F));
        chk_model("R6");
        apply('0);
        chk_model("R6");
    endtask

    task automatic t_latency();
        @(negedge clk);
        pins = NSRC'(1);
        #2;
        chk("R7", int'(lines), 0);
        @(negedge clk);
        chk("R7", int'(lines), 1 << exp_line(0));
        apply('0);
    endtask

    task automatic t_full();
        apply('1);
        chk_model("R8");
        for (int l = 0; l < 4; l++) chk("R8", int'(cnts[l*CW +: CW]), NSRC / 4);
        apply('0);
        chk_model("R8");
    endtask

    initial begin
        t_reset();
        t_single("R2", 0, NR * 4);
        t_single("R3", NR * 4, NSRC);
        t_or();
        t_hold();
        t_simul();
        t_latency();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule